// File: doc/BRIEF.md
# Decimal scale-by-ten unit

This unit scales an unsigned word by a factor of ten in one clock cycle. Depending on a mode select, it either multiplies the operand by ten or divides it by ten. Neither path uses a general-purpose multiplier or an iterative divider, so there is no busy or ready handshake. A new operand can be presented on every cycle. The answer appears in a registered result one clock later, together with a matching valid flag.

The multiply path sums two shifted copies of the operand: one shifted left by one bit and one shifted left by three bits. The divide path works in two steps:

- It multiplies the operand by a fixed reciprocal constant and keeps the upper half of the double-width product. The constant is 0x199A for 16-bit words and 0x1999999A for 32-bit words.
- Because that constant is slightly larger than 2^W/10, the raw quotient can come out one too high for large operands. The unit therefore multiplies the raw quotient back by ten and compares it with the operand. When the product exceeds the operand, it subtracts one from the quotient.

After this correction the quotient equals the truncated quotient for every input.

Top module: `decscale_unit`

## Requirements
- R1: With `op_div` = 0, the result is the operand times ten. It is carried in W+4 bits, so no operand value overflows it.
- R2: With `op_div` = 1, the result is floor(operand / 10) for every operand value, including those where the raw reciprocal estimate is one too high (for W = 16, for example, operand 16389 gives 1638). The top four result bits are zero in this mode.
- R3: `out_valid` is high in the cycle after a clock edge that sampled `in_valid` high, and low after an edge that sampled it low.
- R4: An edge that samples `in_valid` low leaves `result` unchanged.
- R5: While `rst_n` is low, `result` and `out_valid` are zero.
- R6: The mode is sampled together with the operand on the same edge, so alternating modes on back-to-back cycles gives each result the mode of its own operand.
- R7: The reciprocal constant comes from the width parameter: 0x1999999A when W = 32, and 0x199A when W = 16. Only these two widths are supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and mode are valid this cycle |
| op_div | input | 1 | 0 = multiply by ten, 1 = divide by ten |
| operand | input | W | Unsigned operand |
| out_valid | output | 1 | Result register holds a fresh answer |
| result | output | W+4 | Registered product or zero-extended quotient |

## Verification
The assertions assume that `in_valid`, `op_div` and `operand` are never unknown while `rst_n` is high, and that `op_div` is meaningful only when `in_valid` is high. The bench therefore drives every input to a defined value before it releases reset. It changes inputs only on the falling edge, so each rising edge samples settled values. The divide path is swept over all 65536 operands of the default width, which covers every operand that needs the correction. A vector table adds the multiply extremes and a directed test of alternating modes.

// File: rtl/decscale_pkg.sv
package decscale_pkg;

  typedef enum logic {
    MODE_MUL = 1'b0,
    MODE_DIV = 1'b1
  } scale_mode_e;

  // Reciprocal of ten, scaled by 2^w and rounded up: 0x199A / 0x1999999A.
  function automatic logic [31:0] recip_for(input int w);
    if (w == 32) return 32'h1999_999A;
    return 32'h0000_199A;
  endfunction

endpackage

// File: rtl/decscale_mul10.sv
module decscale_mul10 #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  output logic [W+3:0] p
);
  localparam int PW = W + 4;

  logic [PW-1:0] ext;
  logic [PW-1:0] twice;
  logic [PW-1:0] eight;

  always_comb begin
    ext   = {4'b0000, a};
    twice = ext << 1;
    eight = ext << 3;
    p     = twice + eight;
  end
endmodule

// File: rtl/decscale_div10.sv
module decscale_div10 #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] q,
  output logic         fix
);
  import decscale_pkg::*;

  localparam int DW = 2 * W;
  localparam int PW = W + 4;
  localparam logic [31:0] RECIP32 = recip_for(W);
  localparam logic [W-1:0] RECIP = RECIP32[W-1:0];

  logic [DW-1:0] prod;
  logic [W-1:0]  q_raw;
  logic [PW-1:0] back;

  // Upper half of the product is the estimate; the lower half is dropped.
  always_comb begin
    prod  = {{W{1'b0}}, a} * {{W{1'b0}}, RECIP};
    q_raw = prod[DW-1:W];
  end

  // Multiply the estimate back by ten and compare it with the operand.
  decscale_mul10 #(.W(W)) u_back (
    .a (q_raw),
    .p (back)
  );

  always_comb begin
    fix = back > {4'b0000, a};
    q   = q_raw - {{(W-1){1'b0}}, fix};
  end
endmodule

// File: rtl/decscale_unit.sv
module decscale_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         op_div,
  input  logic [W-1:0] operand,
  output logic         out_valid,
  output logic [W+3:0] result
);
  import decscale_pkg::*;

  localparam int PW = W + 4;

  logic [PW-1:0] mul_p;
  logic [W-1:0]  div_q;
  logic          div_fix;
  logic [PW-1:0] next_res;
  scale_mode_e   mode;

  decscale_mul10 #(.W(W)) u_mul (
    .a (operand),
    .p (mul_p)
  );

  decscale_div10 #(.W(W)) u_div (
    .a   (operand),
    .q   (div_q),
    .fix (div_fix)
  );

  always_comb begin
    mode     = scale_mode_e'(op_div);
    next_res = (mode == MODE_DIV) ? {4'b0000, div_q} : mul_p;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

  // Named events for the checks below.
  logic [PW-1:0] q_times_ten;
  logic [PW-1:0] op_ext;
  logic          fix_seen;
  always_comb begin
    q_times_ten = PW'(div_q) * PW'(10);
    op_ext      = {4'b0000, operand};
    fix_seen    = div_fix;
  end

  assert_valid_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  assert_mul_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_div) |-> (mul_p == PW'(operand) * PW'(10)));
  assert_div_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_div) |-> ((q_times_ten <= op_ext) && (op_ext - q_times_ten < PW'(10))));
  assert_fix_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_div && fix_seen) |-> (operand >= W'(10)));
endmodule

// File: tb/decscale_unit_bench.sv
module decscale_unit_bench;
  localparam int W  = 16;
  localparam int PW = W + 4;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          op_div = 1'b0;
  logic [W-1:0]  operand = '0;
  logic          out_valid;
  logic [PW-1:0] result;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Vector table: operand, mode (1 = divide), expected result.
  localparam logic [W-1:0]  V_OP  [NV] = '{16'd0, 16'd1, 16'd6553, 16'd65535, 16'd9,
                                          16'd10, 16'd16384, 16'd16389, 16'd65535, 16'd65529};
  localparam logic          V_DIV [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
                                          1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [PW-1:0] V_EXP [NV] = '{20'd0, 20'd10, 20'd65530, 20'd655350, 20'd0,
                                          20'd1, 20'd1638, 20'd1638, 20'd6553, 20'd6552};

  decscale_unit #(.W(W)) u_decscale_unit (
    .clk, .rst_n, .in_valid, .op_div, .operand, .out_valid, .result
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present one operand at the falling edge; check after the next rising edge.
  task automatic apply(input logic [W-1:0] a, input logic d, input logic [PW-1:0] exp, input string req);
    @(negedge clk);
    operand = a; op_div = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, result, exp);
    check("R3", PW'(out_valid), PW'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R5 result", result, '0);
    check("R5 valid", PW'(out_valid), '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      apply(V_OP[i], V_DIV[i], V_EXP[i], V_DIV[i] ? "R2 table" : "R1 table");

    // R4 and R3: an idle edge keeps the result and drops valid.
    @(negedge clk);
    operand = 16'd777; op_div = 1'b0;
    @(negedge clk);
    check("R4 hold", result, 20'd6552);
    check("R3 idle", PW'(out_valid), '0);

    // R6: alternate modes on back-to-back cycles.
    @(negedge clk);
    in_valid = 1'b1; operand = 16'd1234; op_div = 1'b0;
    @(negedge clk);
    check("R6 mul", result, 20'd12340);
    operand = 16'd1234; op_div = 1'b1;
    @(negedge clk);
    check("R6 div", result, 20'd123);
    operand = 16'd50000; op_div = 1'b0;
    @(negedge clk);
    check("R6 mul2", result, 20'd500000);
    in_valid = 1'b0;

    // R2 and R7: exhaustive divide sweep, streamed one operand per cycle.
    @(negedge clk);
    in_valid = 1'b1; op_div = 1'b1; operand = '0;
    for (int k = 0; k < 65536; k++) begin
      @(negedge clk);
      check("R7 sweep", result, PW'(k / 10));
      operand = W'(k + 1);
    end
    in_valid = 1'b0;

    // R5: reset in mid-stream clears both outputs.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R5 reset result", result, '0);
    check("R5 reset valid", PW'(out_valid), '0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule